// File: doc/BRIEF.md
# Asynchronous Serial Frame Transmitter

This block turns parallel characters into asynchronous serial frames on one output line. A character enters a one-entry holding buffer through a valid/ready handshake. When the shifter is free, the character moves into a frame shift register of up to 11 bits. Each bit is then driven onto the line for a fixed number of baud ticks. An external divider supplies the tick as a single-cycle enable. The block does not contain the divider.

Configuration inputs select the character length (8 or 9 bits) and whether a parity bit is generated. The parity bit, when enabled, takes the place of the top data bit, and even or odd parity can be chosen. A break request sends frames of all zeros instead of characters. Two flags report whether the holding buffer is free and whether all transmission has finished.

Top module: `async_frame_tx`

## Requirements
- R1: After reset `txLine` is 1, `bufEmpty` is 1, `txDone` is 1 and `inReady` is 1. The line stays at 1 whenever nothing is being sent.
- R2: Each frame is sent in this order: one start bit of 0, the data bits least significant first, then one stop bit of 1. With `cfgNineBit`=0 a frame is 10 bits long and with `cfgNineBit`=1 it is 11 bits long. Configuration is sampled when a frame is loaded.
- R3: Every bit of a frame lasts exactly `OVS` (16) `baudTick` pulses. `txLine` never changes in a cycle that has no tick.
- R4: With `cfgParityEn`=1, the highest data bit position (bit 7 in 8-bit mode, bit 8 in 9-bit mode) carries a parity bit instead of data. That input bit is ignored. The parity bit is the XOR of the remaining data bits when `cfgParityOdd`=0, and its inverse when `cfgParityOdd`=1.
- R5: `inReady` is 1 exactly when the holding buffer is free, and `bufEmpty` mirrors it. A character is accepted on a clock edge where `inValid` and `inReady` are both 1. While the buffer is full, input data does not replace the buffered character.
- R6: A buffered character moves into the shifter on a baud tick while the shifter is idle, or on the tick that ends a stop bit. Back-to-back frames therefore have no idle gap. `bufEmpty` rises at this transfer.
- R7: `txDone` is 1 exactly when the shifter is idle and the holding buffer is empty. It is 0 during every frame.
- R8: When `cfgBreak` is 1 at a load point, the block sends a frame of frame length made entirely of zeros. Break has priority over a buffered character, and the character stays in the buffer. Break frames repeat while `cfgBreak` is held. Afterwards the line returns to 1, or the buffered character follows with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | 9 | Character to send (bit 8 used in 9-bit mode only) |
| inValid | input | 1 | Character offered |
| inReady | output | 1 | Holding buffer can accept a character |
| cfgNineBit | input | 1 | 1 = 9-bit characters, 0 = 8-bit |
| cfgParityEn | input | 1 | 1 = top data bit replaced by generated parity |
| cfgParityOdd | input | 1 | 1 = odd parity, 0 = even parity |
| cfgBreak | input | 1 | Send all-zero break frames |
| baudTick | input | 1 | One pulse per oversampled baud period |
| txLine | output | 1 | Serial output, idle high |
| bufEmpty | output | 1 | Holding buffer is empty |
| txDone | output | 1 | Nothing buffered and line idle |

## Verification
The end of a stop bit and the loading of the next frame can fall on the same baud tick. Two cases provoke this. In the first, a second character is written while the first frame is still on the line. In the second, a break is cleared while a character waits in the buffer. Both cases are judged at the ports: the bench requires the start bit of the following frame to appear in the very cycle after the last stop or break bit ends, and the total low time across a break plus the next start bit to equal exactly 11 or 10 bit times plus one.

// File: rtl/aftx_pkg.sv
package aftx_pkg;

  // Strobes issued by the control unit to the datapath, one cycle each
  typedef struct packed {
    logic takeIn;     // capture inData into the holding buffer
    logic loadChar;   // move the buffered character into the shifter
    logic loadBreak;  // fill the shifter with an all-zero frame
    logic shiftBit;   // advance the shifter by one bit
    logic goIdle;     // frame finished with nothing to follow: force line high
  } txStrobe_t;

endpackage

// File: rtl/aftx_ctrl.sv
module aftx_ctrl
  import aftx_pkg::*;
#(
  parameter int OVS     = 16,
  parameter int FRAME_W = 11
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      baudTick,
  input  logic      inValid,
  input  logic      cfgNineBit,
  input  logic      cfgBreak,
  output txStrobe_t stb,
  output logic      bufFull,
  output logic      busy
);

  localparam int CNT_W = $clog2(OVS);
  localparam int IDX_W = $clog2(FRAME_W);

  logic [CNT_W-1:0] tickCnt;
  logic [IDX_W-1:0] bitIdx;
  logic [IDX_W-1:0] lastIdx;

  logic bitEnd;
  logic frameEnd;
  logic loadSlot;
  logic loadAny;

  always_comb begin
    bitEnd        = busy && baudTick && (tickCnt == CNT_W'(OVS - 1));
    frameEnd      = bitEnd && (bitIdx == lastIdx);
    loadSlot      = baudTick && (!busy || frameEnd);
    stb.loadBreak = loadSlot && cfgBreak;
    stb.loadChar  = loadSlot && !cfgBreak && bufFull;
    loadAny       = stb.loadBreak || stb.loadChar;
    stb.shiftBit  = bitEnd && !frameEnd;
    stb.goIdle    = frameEnd && !loadAny;
    stb.takeIn    = inValid && !bufFull;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy    <= 1'b0;
      bufFull <= 1'b0;
      tickCnt <= '0;
      bitIdx  <= '0;
      lastIdx <= IDX_W'(FRAME_W - 1);
    end else begin
      if (stb.loadChar)    bufFull <= 1'b0;
      else if (stb.takeIn) bufFull <= 1'b1;

      if (loadAny) begin
        busy    <= 1'b1;
        tickCnt <= '0;
        bitIdx  <= '0;
        lastIdx <= cfgNineBit ? IDX_W'(FRAME_W - 1) : IDX_W'(FRAME_W - 2);
      end else if (stb.goIdle) begin
        busy    <= 1'b0;
        tickCnt <= '0;
      end else if (bitEnd) begin
        tickCnt <= '0;
        bitIdx  <= bitIdx + 1'b1;
      end else if (busy && baudTick) begin
        tickCnt <= tickCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/aftx_dp.sv
module aftx_dp
  import aftx_pkg::*;
#(
  parameter int DATA_W  = 9,
  parameter int FRAME_W = DATA_W + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         stb,
  input  logic [DATA_W-1:0] inData,
  input  logic              cfgNineBit,
  input  logic              cfgParityEn,
  input  logic              cfgParityOdd,
  output logic              txLine
);

  logic [DATA_W-1:0]  bufData;
  logic [DATA_W-1:0]  payload;
  logic [FRAME_W-1:0] charFrame;
  logic [FRAME_W-1:0] shReg;
  logic               parBit;
  int                 charLen;
  int                 dataLen;

  // Assemble start bit, payload (with optional parity at the top slot) and stop bits
  always_comb begin
    charLen = cfgNineBit ? DATA_W : DATA_W - 1;
    dataLen = cfgParityEn ? charLen - 1 : charLen;
    payload = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < dataLen) payload[i] = bufData[i];
    end
    parBit = (^payload) ^ cfgParityOdd;
    if (cfgParityEn) payload[charLen-1] = parBit;
    charFrame    = '1;
    charFrame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < charLen) charFrame[i+1] = payload[i];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bufData <= '0;
      shReg   <= '1;
    end else begin
      if (stb.takeIn) bufData <= inData;
      if (stb.loadChar)       shReg <= charFrame;
      else if (stb.loadBreak) shReg <= '0;
      else if (stb.shiftBit)  shReg <= {1'b1, shReg[FRAME_W-1:1]};
      else if (stb.goIdle)    shReg <= '1;
    end
  end

  assign txLine = shReg[0];

endmodule

// File: rtl/async_frame_tx.sv
module async_frame_tx
  import aftx_pkg::*;
#(
  parameter int OVS    = 16,
  parameter int DATA_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  output logic              inReady,
  input  logic              cfgNineBit,
  input  logic              cfgParityEn,
  input  logic              cfgParityOdd,
  input  logic              cfgBreak,
  input  logic              baudTick,
  output logic              txLine,
  output logic              bufEmpty,
  output logic              txDone
);

  localparam int FRAME_W = DATA_W + 2;

  txStrobe_t stb;
  logic      bufFull;
  logic      busy;

  aftx_ctrl #(.OVS(OVS), .FRAME_W(FRAME_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .baudTick   (baudTick),
    .inValid    (inValid),
    .cfgNineBit (cfgNineBit),
    .cfgBreak   (cfgBreak),
    .stb        (stb),
    .bufFull    (bufFull),
    .busy       (busy)
  );

  aftx_dp #(.DATA_W(DATA_W), .FRAME_W(FRAME_W)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .inData       (inData),
    .cfgNineBit   (cfgNineBit),
    .cfgParityEn  (cfgParityEn),
    .cfgParityOdd (cfgParityOdd),
    .txLine       (txLine)
  );

  assign inReady  = !bufFull;
  assign bufEmpty = !bufFull;
  assign txDone   = !busy && !bufFull;

endmodule

// File: rtl/async_frame_tx_chk.sv
module async_frame_tx_chk (
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic inReady,
  input logic baudTick,
  input logic txLine,
  input logic bufEmpty,
  input logic txDone
);

  // R1: an idle transmitter holds the line high
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> txLine);

  // R3: the line only moves on a baud tick
  a_r3_no_tick_stable: assert property (@(posedge clk) disable iff (!rstN)
    !baudTick |=> $stable(txLine));

  // R5: an accepted character fills the buffer
  a_r5_accept_fills: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !bufEmpty);

  // R6: the buffer only empties by handing its character to the shifter
  a_r6_transfer_busy: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bufEmpty) |-> !txDone);

  // R7: done implies nothing waits in the buffer
  a_r7_done_empty: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> bufEmpty);

endmodule

bind async_frame_tx async_frame_tx_chk chk_i (.*);

// File: tb/async_frame_tx_tb.sv
`timescale 1ns/1ps
module async_frame_tx_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [8:0] inData = '0;
  logic       inValid = 1'b0;
  logic       inReady;
  logic       cfgNineBit = 1'b0;
  logic       cfgParityEn = 1'b0;
  logic       cfgParityOdd = 1'b0;
  logic       cfgBreak = 1'b0;
  logic       baudTick = 1'b0;
  logic       txLine;
  logic       bufEmpty;
  logic       txDone;

  int nChecks = 0;
  int nFail   = 0;
  int tickDiv = 1;   // 0 = no ticks
  int tickCnt = 0;

  always #10 clk = ~clk;   // 50 MHz

  async_frame_tx dut_i (.*);

  // Baud tick generator, updated away from the active edge
  always @(negedge clk) begin
    if (tickDiv == 0) baudTick <= 1'b0;
    else begin
      baudTick <= (tickCnt == 0);
      tickCnt  <= (tickCnt + 1 >= tickDiv) ? 0 : tickCnt + 1;
    end
  end

  // {nine, parEn, parOdd, data[8:0], frame bits in send order (leftmost first, padded with 1)}
  localparam int NV = 6;
  localparam logic [22:0] VEC [NV] = '{
    {3'b000, 9'h055, 11'b01010101011},
    {3'b010, 9'h083, 11'b01100000011},
    {3'b011, 9'h003, 11'b01100000111},
    {3'b100, 9'h1A5, 11'b01010010111},
    {3'b110, 9'h0F0, 11'b00000111101},
    {3'b111, 9'h001, 11'b01000000001}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic sendChar(input logic [8:0] d);
    @(negedge clk);
    inData  = d;
    inValid = 1'b1;
    while (!inReady) @(negedge clk);
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic waitStart();
    int t = 0;
    while (txLine !== 1'b0 && t < 5000) begin
      @(negedge clk);
      t++;
    end
  endtask

  // Aligns to the first low negedge (offset 0), samples mid-bit, ends at offset 16*(len-1)+8
  task automatic captureFrame(input int len, output logic [10:0] bits);
    int pos = 0;
    bits = '1;
    waitStart();
    for (int b = 0; b < len; b++) begin
      repeat (16 * b + 8 - pos) @(negedge clk);
      pos = 16 * b + 8;
      bits[10-b] = txLine;
    end
  endtask

  task automatic waitDone();
    int t = 0;
    while (txDone !== 1'b1 && t < 5000) begin
      @(negedge clk);
      t++;
    end
  endtask

  function automatic int countLow();
    return 0;
  endfunction

  initial begin
    #(20ns * 150000);
    nFail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [10:0] got;
    int low;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 txLine", txLine, 1);
    chk("R1 bufEmpty", bufEmpty, 1);
    chk("R1 txDone", txDone, 1);
    chk("R1 inReady", inReady, 1);

    // Vector table: framing, lengths, parity (R2, R4, R6, R7)
    for (int v = 0; v < NV; v++) begin
      int len;
      @(negedge clk);
      cfgNineBit   = VEC[v][22];
      cfgParityEn  = VEC[v][21];
      cfgParityOdd = VEC[v][20];
      len = cfgNineBit ? 11 : 10;
      sendChar(VEC[v][19:11]);
      captureFrame(len, got);
      chk($sformatf("R2/R4 frame vec%0d", v), got, VEC[v][10:0]);
      chk("R6 bufEmpty after transfer", bufEmpty, 1);
      chk("R7 txDone low while busy", txDone, 0);
      repeat (16) @(negedge clk);
      chk("R7 txDone after frame", txDone, 1);
      chk("R1 line idle after frame", txLine, 1);
    end

    // R5/R3: no ticks, buffer holds first character, second offer refused
    tickDiv = 0;
    cfgNineBit = 1'b0; cfgParityEn = 1'b0;
    repeat (2) @(negedge clk);
    sendChar(9'h0F);
    chk("R5 bufEmpty after accept", bufEmpty, 0);
    chk("R5 inReady when full", inReady, 0);
    inData = 9'h0AA; inValid = 1'b1;
    repeat (40) @(negedge clk);
    chk("R3 line stable without ticks", txLine, 1);
    inValid = 1'b0;
    tickDiv = 1;
    captureFrame(10, got);
    chk("R5 buffered data kept", got, 11'b01111000011);
    waitDone();

    // R3: sparse ticks, start bit spans 16 ticks of 3 cycles
    tickDiv = 3;
    sendChar(9'h001);
    waitStart();
    low = 0;
    while (txLine === 1'b0 && low < 1000) begin
      @(negedge clk);
      low++;
    end
    chk("R3 start bit cycles", low, 48);
    waitDone();
    tickDiv = 1;

    // R6: back-to-back frames without a gap
    fork
      begin sendChar(9'h0F); sendChar(9'hF0); end
    join_none
    captureFrame(10, got);
    chk("R6 first frame", got, 11'b01111000011);
    repeat (8) @(negedge clk);
    chk("R6 next start follows stop", txLine, 0);
    captureFrame(10, got);
    chk("R6 second frame", got, 11'b00000111111);
    waitDone();
    chk("R7 done after pair", txDone, 1);

    // R8: break in 8-bit mode with a character waiting
    @(negedge clk);
    cfgBreak = 1'b1;
    waitStart();
    fork sendChar(9'h001); join_none
    low = 0;
    repeat (80) begin @(negedge clk); low++; end
    chk("R8 buffer held during break", bufEmpty, 0);
    cfgBreak = 1'b0;
    while (txLine === 1'b0 && low < 2000) begin
      @(negedge clk);
      low++;
    end
    chk("R8 break plus start low cycles", low, 176);
    waitDone();
    chk("R8 line high after", txLine, 1);

    // R8: 9-bit break with nothing waiting returns to idle
    cfgNineBit = 1'b1;
    @(negedge clk);
    cfgBreak = 1'b1;
    waitStart();
    low = 0;
    repeat (20) begin @(negedge clk); low++; end
    cfgBreak = 1'b0;
    while (txLine === 1'b0 && low < 2000) begin
      @(negedge clk);
      low++;
    end
    chk("R8 9-bit break length", low, 176);
    chk("R8 done after break", txDone, 1);

    $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
    $finish;
  end

endmodule